// File: doc/BRIEF.md
# Receive Frame Aligner and Pad Stripper

This unit sits in a network receive path, between the byte stream that comes from the MAC and the receive FIFO. It handles one frame at a time. Input bytes arrive on a valid/ready handshake with start-of-frame and end-of-frame markers. Output bytes leave on a valid/ready handshake toward the FIFO. A stall on the output side holds back the input side, so no byte is lost or repeated.

When alignment is on, the unit writes two filler bytes ahead of the first destination-address byte. This places the data field of the frame on a 4-byte boundary, provided the buffers downstream start and end on multiples of four. When stripping is on, the unit decodes the 802.3 length field, taken as bytes 12 and 13 of the frame with the most significant byte first. If that value is at most 1500 and below 46, the unit forwards only the 14 header bytes plus the stated payload length, and it drops the pad and FCS that follow.

Each frame ends with a one-cycle report of the message byte count. The count never includes the fillers. Both enables are captured when a frame starts.

The control sits in one state machine with four states:
- `ST_IDLE` waits for a start byte. It takes the transition *start-plain* to `ST_BODY`, or to `ST_IDLE` for a one-byte frame. It takes the transition *start-aligned* to `ST_FILL`. It also discards any byte that arrives without a start marker.
- `ST_FILL` emits the second filler and takes the transition *fill-done* to `ST_BODY`.
- `ST_BODY` forwards bytes. It takes the transition *cut* to `ST_TRIM` on the first byte beyond the kept length, or *end* to `ST_IDLE` on the end byte.
- `ST_TRIM` consumes the remaining bytes without output. It takes the transition *end* to `ST_IDLE` on the end byte.

Top module: `rx_align_strip`

## Requirements
- R1: After reset, `out_valid` and `cnt_valid` are 0.
- R2: With alignment captured as 1, exactly two filler bytes of arbitrary value are emitted before the first frame byte. With alignment captured as 0, the first output byte of the frame is the first frame byte.
- R3: The reported count equals the number of frame bytes forwarded, and it never includes the fillers.
- R4: With stripping captured as 1 and a length field L below 46 (field = byte 12 × 256 + byte 13), only the first 14+L bytes are forwarded. The rest, up to and including the end byte, are discarded.
- R5: In the case of R4, the reported count is 14+L.
- R6: A length field of 46 or more, including type values above 1500, causes no stripping. The whole frame, FCS included, is forwarded and counted.
- R7: Both enables are sampled on the cycle the start byte is taken, or on the cycle the first filler is emitted. Changing them later in the frame has no effect.
- R8: Under output backpressure, `out_data` holds while `out_valid` is high and `out_ready` is low. Every expected byte appears exactly once and in order.
- R9: Bytes presented while idle without the start marker are discarded and produce no output.
- R10: With stripping captured as 0, a frame whose length field is below 46 is forwarded and counted whole.
- R11: `cnt_valid` pulses for one cycle, in the cycle after the clock edge that accepts the end byte, and `cnt_bytes` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_align_en | input | 1 | Insert two fillers per frame |
| cfg_strip_en | input | 1 | Remove pad and FCS of short frames |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_ready | output | 1 | Input byte accepted at this edge when valid |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream takes the output byte |
| cnt_valid | output | 1 | Frame count report strobe |
| cnt_bytes | output | 16 | Message byte count of the frame just ended |

## Verification
A forwarded byte appears on `out_data` one cycle after the edge that accepts it, because it passes through a single output register. The first filler appears one cycle after the edge at which the start byte is first presented with a free output slot. The count strobe comes one cycle after the edge that takes the end byte. The bench samples all handshakes 2 ns before each rising edge. It keeps the expected bytes and counts in queues and pops one entry per observed transfer, so stalls shift the expected values without breaking the match. A separate flag, kept from the previous sample, confirms that the count strobe follows the edge that took the end byte.

// File: rtl/rx_align_strip_pkg.sv
package rx_align_strip_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_BODY = 2'd2,
        ST_TRIM = 2'd3
    } ras_state_e;
endpackage

// File: rtl/ras_out_stage.sv
module ras_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              out_ready,
    output logic              slot_free,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    assign slot_free = !out_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (push) begin
            out_valid <= 1'b1;
            out_data  <= push_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ras_len_decode.sv
module ras_len_decode #(
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 16,
    parameter int HDR_B   = 14,
    parameter int MIN_PAY = 46,
    parameter int MAX_LEN = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_strip_en,
    input  logic              take,
    input  logic [CNT_W-1:0]  byte_idx,
    input  logic [DATA_W-1:0] data,
    output logic              strip_act,
    output logic [CNT_W-1:0]  keep_lim
);
    localparam int LEN_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] IDX_HI = CNT_W'(HDR_B - 2);
    localparam logic [CNT_W-1:0] IDX_LO = CNT_W'(HDR_B - 1);

    logic              strip_en_q;
    logic [DATA_W-1:0] len_hi;
    logic [LEN_W-1:0]  len_val;
    logic              short_len;

    assign len_val   = {len_hi, data};
    assign short_len = (int'(len_val) <= MAX_LEN) && (int'(len_val) < MIN_PAY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strip_en_q <= 1'b0;
            strip_act  <= 1'b0;
            len_hi     <= '0;
            keep_lim   <= '0;
        end else if (start) begin
            strip_en_q <= cfg_strip_en;
            strip_act  <= 1'b0;
            len_hi     <= '0;
            keep_lim   <= '0;
        end else if (take && byte_idx == IDX_HI) begin
            len_hi <= data;
        end else if (take && byte_idx == IDX_LO) begin
            strip_act <= strip_en_q && short_len;
            keep_lim  <= CNT_W'(HDR_B) + CNT_W'(len_val);
        end
    end
endmodule

// File: rtl/ras_frame_count.sv
module ras_frame_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             take,
    input  logic             emit,
    input  logic             last,
    output logic [CNT_W-1:0] idx,
    output logic             cnt_valid,
    output logic [CNT_W-1:0] cnt_bytes
);
    logic [CNT_W-1:0] idx_base;
    logic [CNT_W-1:0] fwd;
    logic [CNT_W-1:0] fwd_base;
    logic [CNT_W-1:0] fwd_nxt;

    assign idx_base = start ? '0 : idx;
    assign fwd_base = start ? '0 : fwd;
    assign fwd_nxt  = fwd_base + CNT_W'(emit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            fwd       <= '0;
            cnt_valid <= 1'b0;
            cnt_bytes <= '0;
        end else begin
            if (take || start) idx <= idx_base + CNT_W'(take);
            if (emit || start) fwd <= fwd_nxt;
            cnt_valid <= take && last;
            if (take && last) cnt_bytes <= fwd_nxt;
        end
    end
endmodule

// File: rtl/rx_align_strip.sv
module rx_align_strip
    import rx_align_strip_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          CNT_W     = 16,
    parameter int          HDR_B     = 14,
    parameter int          MIN_PAY   = 46,
    parameter int          MAX_LEN   = 1500,
    parameter logic [7:0]  FILL_BYTE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_align_en,
    input  logic              cfg_strip_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              cnt_valid,
    output logic [CNT_W-1:0]  cnt_bytes
);
    ras_state_e        state, nxt;
    logic              slot_free;
    logic              push;
    logic [DATA_W-1:0] push_data;
    logic              take;
    logic              emit;
    logic              start;
    logic              strip_act;
    logic [CNT_W-1:0]  keep_lim;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  byte_idx;
    logic              keep_ok;

    assign byte_idx = (state == ST_IDLE) ? '0 : idx;
    assign keep_ok  = !(strip_act && (idx >= keep_lim));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        in_ready  = 1'b0;
        push      = 1'b0;
        push_data = in_data;
        take      = 1'b0;
        emit      = 1'b0;
        start     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid && in_sof) begin
                    if (cfg_align_en) begin
                        if (slot_free) begin
                            push      = 1'b1;
                            push_data = FILL_BYTE;
                            start     = 1'b1;
                            nxt       = ST_FILL;
                        end
                    end else begin
                        in_ready = slot_free;
                        if (slot_free) begin
                            start = 1'b1;
                            take  = 1'b1;
                            push  = 1'b1;
                            emit  = 1'b1;
                            nxt   = in_eof ? ST_IDLE : ST_BODY;
                        end
                    end
                end else begin
                    in_ready = 1'b1;
                end
            end
            ST_FILL: begin
                if (slot_free) begin
                    push      = 1'b1;
                    push_data = FILL_BYTE;
                    nxt       = ST_BODY;
                end
            end
            ST_BODY: begin
                if (keep_ok) begin
                    in_ready = slot_free;
                    if (in_valid && slot_free) begin
                        take = 1'b1;
                        push = 1'b1;
                        emit = 1'b1;
                        nxt  = in_eof ? ST_IDLE : ST_BODY;
                    end
                end else begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        take = 1'b1;
                        nxt  = in_eof ? ST_IDLE : ST_TRIM;
                    end
                end
            end
            ST_TRIM: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    take = 1'b1;
                    if (in_eof) nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    ras_out_stage #(.DATA_W(DATA_W)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .out_ready (out_ready),
        .slot_free (slot_free),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    ras_len_decode #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .HDR_B(HDR_B),
        .MIN_PAY(MIN_PAY), .MAX_LEN(MAX_LEN)
    ) len_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_strip_en (cfg_strip_en),
        .take         (take),
        .byte_idx     (byte_idx),
        .data         (in_data),
        .strip_act    (strip_act),
        .keep_lim     (keep_lim)
    );

    ras_frame_count #(.CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .take      (take),
        .emit      (emit),
        .last      (in_eof),
        .idx       (idx),
        .cnt_valid (cnt_valid),
        .cnt_bytes (cnt_bytes)
    );
endmodule

// File: rtl/rx_align_strip_chk.sv
module rx_align_strip_chk
    import rx_align_strip_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_eof,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              cnt_valid,
    input logic [CNT_W-1:0]  cnt_bytes,
    input ras_state_e        state,
    input logic              strip_act,
    input logic [CNT_W-1:0]  keep_lim
);
    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_fill_blocks_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !in_ready);

    assert_trim_never_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIM) |-> in_ready);

    assert_cnt_after_eof_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |-> $past(in_valid && in_ready && in_eof));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && strip_act) |-> (cnt_bytes <= keep_lim));
endmodule

bind rx_align_strip rx_align_strip_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eof    (in_eof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .cnt_valid (cnt_valid),
    .cnt_bytes (cnt_bytes),
    .state     (state),
    .strip_act (strip_act),
    .keep_lim  (keep_lim)
);

// File: tb/rx_align_strip_tb_top.sv
`timescale 1ns/1ps
module rx_align_strip_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_align_en = 1'b0, cfg_strip_en = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, out_valid, cnt_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic [15:0] cnt_bytes;

    int    n_run = 0, n_fail = 0, cycles = 0;
    bit    bp = 0, mon_on = 0, prev_eof = 0, prev_stall = 0;
    logic [7:0] prev_data = 8'h00;
    int    exp_b[$];
    string tag_b[$];
    int    exp_c[$];
    string tag_c[$];

    always #5 clk = ~clk;

    rx_align_strip dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_align_en(cfg_align_en), .cfg_strip_en(cfg_strip_en),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .cnt_valid(cnt_valid), .cnt_bytes(cnt_bytes)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        out_ready = bp ? ($urandom_range(0, 3) != 0) : 1'b1;
    end

    // reference comparison, sampled 2 ns before each rising edge
    always @(posedge clk) begin
        #8;
        cycles++;
        if (mon_on) begin
            if (prev_stall)
                check(out_valid && out_data == prev_data, "R8", int'(out_data), int'(prev_data));
            if (out_valid && out_ready) begin
                if (exp_b.size() == 0) check(0, "R8 extra byte", int'(out_data), -1);
                else begin
                    automatic int e = exp_b.pop_front();
                    automatic string t = tag_b.pop_front();
                    check(e < 0 || int'(out_data) == e, t, int'(out_data), e);
                end
            end
            if (cnt_valid) begin
                check(prev_eof, "R11", 1, 1);
                if (exp_c.size() == 0) check(0, "R3 extra count", int'(cnt_bytes), -1);
                else begin
                    automatic int e = exp_c.pop_front();
                    automatic string t = tag_c.pop_front();
                    check(int'(cnt_bytes) == e, t, int'(cnt_bytes), e);
                end
            end
            prev_eof   = in_valid && in_ready && in_eof;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    // present one byte from +1 ns, hold until accepted
    task automatic put(input logic [7:0] d, input bit s, input bit e);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        #7;
        while (!in_ready) #10;
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    function automatic logic [7:0] fbyte(input int i, input int len, input int seed);
        if (i == 12) return 8'(len >> 8);
        if (i == 13) return 8'(len);
        return 8'(i * 7 + seed);
    endfunction

    task automatic send_frame(input bit al, input bit st, input int n, input int len,
                              input bit flip, input string tb, input string tc);
        automatic int keep = n;
        automatic int seed = $urandom_range(0, 255);
        cfg_align_en = al; cfg_strip_en = st;
        if (st && len < 46) keep = (14 + len < n) ? 14 + len : n;
        if (al) begin
            exp_b.push_back(-1); tag_b.push_back("R2");
            exp_b.push_back(-1); tag_b.push_back("R2");
        end
        for (int i = 0; i < keep; i++) begin
            exp_b.push_back(int'(fbyte(i, len, seed)));
            tag_b.push_back(i == 0 ? "R2" : tb);
        end
        exp_c.push_back(keep); tag_c.push_back(tc);
        for (int i = 0; i < n; i++) begin
            put(fbyte(i, len, seed), i == 0, i == n - 1);
            if (flip && i == 0) begin
                cfg_align_en = !al; cfg_strip_en = !st;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #8;
        check(!out_valid, "R1", int'(out_valid), 0);
        check(!cnt_valid, "R1", int'(cnt_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_on = 1;
        @(posedge clk); #1;
        send_frame(0, 0, 60, 20, 0, "R10", "R10");
        send_frame(1, 0, 64, 100, 0, "R6", "R3");
        send_frame(0, 1, 64, 20, 0, "R4", "R5");
        send_frame(1, 1, 64, 0, 0, "R4", "R5");
        send_frame(1, 1, 70, 46, 0, "R6", "R6");
        send_frame(0, 1, 64, 45, 0, "R4", "R5");
        send_frame(0, 1, 64, 16'h0800, 0, "R6", "R6");
        send_frame(0, 1, 64, 10, 1, "R7", "R7");
        send_frame(1, 0, 64, 10, 1, "R7", "R7");
        cfg_align_en = 0;
        put(8'hA5, 0, 0); put(8'h5A, 0, 1); put(8'h33, 0, 0);
        send_frame(0, 0, 20, 30, 0, "R9", "R9");
        send_frame(1, 1, 1, 0, 0, "R3", "R3");
        bp = 1;
        send_frame(1, 1, 64, 20, 0, "R8", "R5");
        send_frame(1, 0, 64, 200, 0, "R8", "R8");
        send_frame(0, 1, 64, 0, 0, "R8", "R5");
        send_frame(0, 0, 1, 0, 0, "R8", "R3");
        bp = 0;
        repeat (20) @(posedge clk);
        #2;
        check(exp_b.size() == 0, "R8 missing bytes", exp_b.size(), 0);
        check(exp_c.size() == 0, "R11 missing counts", exp_c.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule